// File: doc/BRIEF.md
# Boot Sector Guard

This block sits between a flash command decoder and the array controller. Each program, sector-erase, chip-erase or identification read request arrives with its address. The block names the erase sector that the address falls in: boot, parameter 1, parameter 2 or main. It decides whether the operation may proceed and returns the address span the operation covers. It also holds a set-only lockout bit that protects the boot sector.

Two parameters set the layout. `TOP_BOOT` places the boot sector at the highest addresses instead of the lowest. `WORD_MODE` selects 16-bit addressing, which halves every sector size and drops one address bit. The lockout bit is set by a one-cycle pulse from the command decoder once that decoder has recognised the six-write lockout sequence. A high-voltage override flag reaches the block as a single digital input. While that flag is high, a locked boot sector can still be changed.

Requests use a valid/ready channel, and so do responses. Holding the response stage is the only storage for requests. `req_ready` is high when the response register is empty, or when it is being emptied in the same cycle (`!rsp_valid || rsp_ready`). A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. Its response appears with `rsp_valid` after that edge. The response stays unchanged until an edge where `rsp_ready` is high.

Top module: `boot_guard`

## Requirements
- R1: In the bottom-boot byte layout, `rsp_sector` reports 0 (boot) for 00000–03FFF, 1 (parameter 1) for 04000–05FFF, 2 (parameter 2) for 06000–07FFF and 3 (main) for 08000–FFFFF.
- R2: In the top-boot word layout, the boot sector (0) is 7E000–7FFFF, parameter 1 (1) is 7D000–7DFFF directly below it, parameter 2 (2) is 7C000–7CFFF, and main (3) is 00000–7BFFF.
- R3: The request kind is encoded on `req_kind` as 0 program, 1 sector erase, 2 chip erase and 3 identification read. A sector erase returns `rsp_lo`/`rsp_hi` equal to the bounds of the addressed sector. A program or identification read returns `rsp_lo` = `rsp_hi` = the request address.
- R4: While the boot sector is locked and the override is low, a program or sector erase aimed at the boot sector returns `rsp_permit` = 0. The same operations aimed at any other sector return 1.
- R5: A chip erase always returns `rsp_permit` = 1. Its span is the whole address space when the boot sector is open. When the boot sector is locked and the override is low, the span excludes the boot sector: 04000–FFFFF for bottom-boot byte and 00000–7DFFF for top-boot word.
- R6: With the override high when the request is accepted, a locked boot sector behaves as unlocked for program, sector erase and chip erase. Once the override is low again, boot requests are refused.
- R7: An identification read returns the lock state on `rsp_lock_bit` (1 = locked) only at the boot sector base address plus 2. At every other address, and for every other request kind, it returns 0. Identification reads return `rsp_permit` = 0.
- R8: The lock bit starts cleared at power-up. It becomes set on the clock edge after `lock_set` is sampled high, and affects requests accepted after that edge. Neither `rst_n` nor any erase clears it.
- R9: During reset, `rsp_valid` is 0. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, every response field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the handshake stage |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_kind | input | 2 | Operation kind (see R3) |
| req_addr | input | AW | Target address (20 bits byte mode, 19 word mode) |
| hv_override | input | 1 | High-voltage lockout bypass flag |
| lock_set | input | 1 | One-cycle pulse that sets the boot lockout |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_sector | output | 2 | Sector of the request address |
| rsp_permit | output | 1 | Operation allowed |
| rsp_lo | output | AW | First address of covered span |
| rsp_hi | output | AW | Last address of covered span |
| rsp_lock_bit | output | 1 | Lock state returned by an identification read |

## Verification
The sector map is exercised at both edges of every sector in two layouts. These are bottom-boot byte mode and top-boot word mode, run side by side. The pairs separate off-by-one boundaries and a wrong mirror direction. Each request kind is then repeated in three states: unlocked, locked, and locked with override. This separates a missing lock, a lock that ignores the override, and a chip erase that refuses instead of shrinking its span. A mid-run reset followed by an identification read shows whether the lock survives reset. A stalled response with a second request waiting shows whether the response is held and whether ready is gated.

// File: rtl/boot_guard_pkg.sv
package boot_guard_pkg;
  typedef enum logic [1:0] {
    OP_PROGRAM      = 2'd0,
    OP_SECTOR_ERASE = 2'd1,
    OP_CHIP_ERASE   = 2'd2,
    OP_ID_READ      = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    SEC_BOOT   = 2'd0,
    SEC_PARAM1 = 2'd1,
    SEC_PARAM2 = 2'd2,
    SEC_MAIN   = 2'd3
  } sector_e;
endpackage

// File: rtl/bg_sector_map.sv
module bg_sector_map
  import boot_guard_pkg::*;
#(
  parameter int AW       = 20,
  parameter int BOOT_SZ  = 'h4000,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [AW-1:0] addr,
  output sector_e       sector,
  output logic [AW-1:0] sec_lo,
  output logic [AW-1:0] sec_hi,
  output logic [AW-1:0] boot_base,
  output logic [AW-1:0] rest_lo,
  output logic [AW-1:0] rest_hi
);
  localparam int PAR_SZ = BOOT_SZ / 2;
  localparam logic [AW-1:0] MAX_A = '1;

  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [AW-1:0] BOOT_LO = MAX_A - AW'(BOOT_SZ - 1);
      localparam logic [AW-1:0] P1_LO   = BOOT_LO - AW'(PAR_SZ);
      localparam logic [AW-1:0] P2_LO   = P1_LO - AW'(PAR_SZ);
      assign boot_base = BOOT_LO;
      assign rest_lo   = '0;
      assign rest_hi   = BOOT_LO - 1'b1;
      always_comb begin
        if (addr >= BOOT_LO) begin
          sector = SEC_BOOT;   sec_lo = BOOT_LO; sec_hi = MAX_A;
        end else if (addr >= P1_LO) begin
          sector = SEC_PARAM1; sec_lo = P1_LO;   sec_hi = BOOT_LO - 1'b1;
        end else if (addr >= P2_LO) begin
          sector = SEC_PARAM2; sec_lo = P2_LO;   sec_hi = P1_LO - 1'b1;
        end else begin
          sector = SEC_MAIN;   sec_lo = '0;      sec_hi = P2_LO - 1'b1;
        end
      end
    end else begin : g_bottom
      localparam logic [AW-1:0] P1_LO   = AW'(BOOT_SZ);
      localparam logic [AW-1:0] P2_LO   = P1_LO + AW'(PAR_SZ);
      localparam logic [AW-1:0] MAIN_LO = P2_LO + AW'(PAR_SZ);
      assign boot_base = '0;
      assign rest_lo   = P1_LO;
      assign rest_hi   = MAX_A;
      always_comb begin
        if (addr < P1_LO) begin
          sector = SEC_BOOT;   sec_lo = '0;      sec_hi = P1_LO - 1'b1;
        end else if (addr < P2_LO) begin
          sector = SEC_PARAM1; sec_lo = P1_LO;   sec_hi = P2_LO - 1'b1;
        end else if (addr < MAIN_LO) begin
          sector = SEC_PARAM2; sec_lo = P2_LO;   sec_hi = MAIN_LO - 1'b1;
        end else begin
          sector = SEC_MAIN;   sec_lo = MAIN_LO; sec_hi = MAX_A;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bg_lock_keeper.sv
module bg_lock_keeper (
  input  logic clk,
  input  logic rst_n,
  input  logic set_pulse,
  output logic locked
);
  // Power-up value only; the reset input deliberately does not touch it.
  logic lock_q = 1'b0;

  always_ff @(posedge clk) begin
    if (set_pulse) lock_q <= 1'b1;
  end

  assign locked = lock_q;

  // R8: once set, the lock never clears
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R8: a set pulse takes effect on the following edge
  a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_pulse |=> lock_q);
endmodule

// File: rtl/bg_access_judge.sv
module bg_access_judge
  import boot_guard_pkg::*;
#(
  parameter int AW = 20
) (
  input  op_kind_e      kind,
  input  logic [AW-1:0] addr,
  input  sector_e       sector,
  input  logic [AW-1:0] sec_lo,
  input  logic [AW-1:0] sec_hi,
  input  logic [AW-1:0] boot_base,
  input  logic [AW-1:0] rest_lo,
  input  logic [AW-1:0] rest_hi,
  input  logic          locked,
  input  logic          override,
  output logic          permit,
  output logic [AW-1:0] span_lo,
  output logic [AW-1:0] span_hi,
  output logic          lock_bit
);
  logic boot_open;
  assign boot_open = !locked || override;

  always_comb begin
    permit   = 1'b0;
    span_lo  = addr;
    span_hi  = addr;
    lock_bit = 1'b0;
    unique case (kind)
      OP_PROGRAM: permit = (sector != SEC_BOOT) || boot_open;
      OP_SECTOR_ERASE: begin
        permit  = (sector != SEC_BOOT) || boot_open;
        span_lo = sec_lo;
        span_hi = sec_hi;
      end
      OP_CHIP_ERASE: begin
        permit  = 1'b1;
        span_lo = boot_open ? '0 : rest_lo;
        span_hi = boot_open ? '1 : rest_hi;
      end
      OP_ID_READ: lock_bit = locked && (addr == boot_base + AW'(2));
      default: permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/boot_guard.sv
module boot_guard
  import boot_guard_pkg::*;
#(
  parameter bit TOP_BOOT  = 1'b0,
  parameter bit WORD_MODE = 1'b0,
  parameter int BYTE_AW   = 20,
  parameter int BOOT_LOG2 = 14,
  parameter int AW        = (WORD_MODE ? BYTE_AW - 1 : BYTE_AW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          hv_override,
  input  logic          lock_set,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [1:0]    rsp_sector,
  output logic          rsp_permit,
  output logic [AW-1:0] rsp_lo,
  output logic [AW-1:0] rsp_hi,
  output logic          rsp_lock_bit
);
  localparam int BOOT_SZ = 1 << (BOOT_LOG2 - (WORD_MODE ? 1 : 0));

  op_kind_e      kind;
  sector_e       sector;
  logic [AW-1:0] sec_lo, sec_hi, boot_base, rest_lo, rest_hi;
  logic [AW-1:0] span_lo, span_hi;
  logic          locked, permit, lock_bit, take;

  assign kind = op_kind_e'(req_kind);

  bg_sector_map #(.AW(AW), .BOOT_SZ(BOOT_SZ), .TOP_BOOT(TOP_BOOT)) u_map (
    .addr(req_addr), .sector(sector), .sec_lo(sec_lo), .sec_hi(sec_hi),
    .boot_base(boot_base), .rest_lo(rest_lo), .rest_hi(rest_hi)
  );

  bg_lock_keeper u_lock (
    .clk(clk), .rst_n(rst_n), .set_pulse(lock_set), .locked(locked)
  );

  bg_access_judge #(.AW(AW)) u_judge (
    .kind(kind), .addr(req_addr), .sector(sector), .sec_lo(sec_lo),
    .sec_hi(sec_hi), .boot_base(boot_base), .rest_lo(rest_lo),
    .rest_hi(rest_hi), .locked(locked), .override(hv_override),
    .permit(permit), .span_lo(span_lo), .span_hi(span_hi),
    .lock_bit(lock_bit)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  op_kind_e      kind_q;
  logic [AW-1:0] addr_q;
  logic          open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_sector   <= 2'd0;
      rsp_permit   <= 1'b0;
      rsp_lo       <= '0;
      rsp_hi       <= '0;
      rsp_lock_bit <= 1'b0;
      kind_q       <= OP_PROGRAM;
      addr_q       <= '0;
      open_q       <= 1'b0;
    end else if (take) begin
      rsp_valid    <= 1'b1;
      rsp_sector   <= sector;
      rsp_permit   <= permit;
      rsp_lo       <= span_lo;
      rsp_hi       <= span_hi;
      rsp_lock_bit <= lock_bit;
      kind_q       <= kind;
      addr_q       <= req_addr;
      open_q       <= !locked || hv_override;
    end else if (rsp_ready) begin
      rsp_valid    <= 1'b0;
    end
  end

  // R9: a stalled response holds every field
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_sector) &&
      $stable(rsp_permit) && $stable(rsp_lo) && $stable(rsp_hi) &&
      $stable(rsp_lock_bit));
  // R5: chip erase is never refused
  a_r5_chip_permit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && kind_q == OP_CHIP_ERASE |-> rsp_permit);
  // R3: the span of a non-chip operation covers its own address
  a_r3_span_covers: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && kind_q != OP_CHIP_ERASE |-> rsp_lo <= addr_q && addr_q <= rsp_hi);
  // R4: a closed boot sector refuses program and sector erase
  a_r4_boot_refused: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !open_q && rsp_sector == SEC_BOOT &&
      (kind_q == OP_PROGRAM || kind_q == OP_SECTOR_ERASE) |-> !rsp_permit);
  // R7: lock status only appears on identification reads
  a_r7_id_only: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && kind_q != OP_ID_READ |-> !rsp_lock_bit);
endmodule

// File: tb/boot_guard_bench.sv
module boot_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [19:0] a_addr = '0;
  logic        ovr = 1'b0;
  logic        lock_set = 1'b0;
  logic        rsp_ready = 1'b1;

  logic        a_req_ready, a_rsp_valid, a_permit, a_lock_bit;
  logic [1:0]  a_sector;
  logic [19:0] a_lo, a_hi;
  logic        b_req_ready, b_rsp_valid, b_permit, b_lock_bit;
  logic [1:0]  b_sector;
  logic [18:0] b_lo, b_hi;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  boot_guard u_boot_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(a_req_ready),
    .req_kind(req_kind), .req_addr(a_addr), .hv_override(ovr),
    .lock_set(lock_set), .rsp_valid(a_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_sector(a_sector), .rsp_permit(a_permit), .rsp_lo(a_lo),
    .rsp_hi(a_hi), .rsp_lock_bit(a_lock_bit)
  );

  boot_guard #(.TOP_BOOT(1'b1), .WORD_MODE(1'b1)) u_boot_guard_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_req_ready),
    .req_kind(req_kind), .req_addr(a_addr[18:0]), .hv_override(ovr),
    .lock_set(lock_set), .rsp_valid(b_rsp_valid), .rsp_ready(rsp_ready),
    .rsp_sector(b_sector), .rsp_permit(b_permit), .rsp_lo(b_lo),
    .rsp_hi(b_hi), .rsp_lock_bit(b_lock_bit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic [19:0] ad, input logic ov);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; a_addr = ad; ovr = ov;
    @(negedge clk);
    req_valid = 1'b0; ovr = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 rsp_valid in reset", a_rsp_valid, 0);
    chk("R9 req_ready in reset", a_req_ready, 1);
    rst_n = 1'b1;
    issue(2'd3, 20'h00002, 1'b0);
    chk("R8 power-up unlocked", a_lock_bit, 0);
    chk("R7 id read permit", a_permit, 0);
  endtask

  task automatic t_map_bottom;
    logic [19:0] ad [8] = '{20'h00000, 20'h03FFF, 20'h04000, 20'h05FFF,
                            20'h06000, 20'h07FFF, 20'h08000, 20'hFFFFF};
    for (int i = 0; i < 8; i++) begin
      issue(2'd0, ad[i], 1'b0);
      chk("R1 sector", a_sector, i / 2);
      chk("R3 program lo", a_lo, ad[i]);
      chk("R3 program hi", a_hi, ad[i]);
      chk("R4 unlocked permit", a_permit, 1);
    end
  endtask

  task automatic t_map_top;
    logic [19:0] ad [8] = '{20'h7FFFF, 20'h7E000, 20'h7DFFF, 20'h7D000,
                            20'h7CFFF, 20'h7C000, 20'h7BFFF, 20'h00000};
    for (int i = 0; i < 8; i++) begin
      issue(2'd0, ad[i], 1'b0);
      chk("R2 sector", b_sector, i / 2);
    end
  endtask

  task automatic t_sector_erase;
    issue(2'd1, 20'h05123, 1'b0);
    chk("R3 bottom erase lo", a_lo, 20'h04000);
    chk("R3 bottom erase hi", a_hi, 20'h05FFF);
    issue(2'd1, 20'h7D123, 1'b0);
    chk("R3 top erase lo", b_lo, 19'h7D000);
    chk("R3 top erase hi", b_hi, 19'h7DFFF);
    chk("R3 bottom main lo", a_lo, 20'h08000);
    chk("R3 bottom main hi", a_hi, 20'hFFFFF);
  endtask

  task automatic t_chip_unlocked;
    issue(2'd2, 20'h00000, 1'b0);
    chk("R5 unlocked chip lo", a_lo, 0);
    chk("R5 unlocked chip hi", a_hi, 20'hFFFFF);
    chk("R5 unlocked chip hi top", b_hi, 19'h7FFFF);
    chk("R5 permit", a_permit, 1);
  endtask

  task automatic t_lock;
    @(negedge clk); lock_set = 1'b1;
    @(negedge clk); lock_set = 1'b0;
    issue(2'd3, 20'h00002, 1'b0);
    chk("R7 lock bit bottom", a_lock_bit, 1);
    issue(2'd3, 20'h00003, 1'b0);
    chk("R7 other address", a_lock_bit, 0);
    issue(2'd3, 20'h7E002, 1'b0);
    chk("R7 lock bit top", b_lock_bit, 1);
    chk("R7 bottom at foreign address", a_lock_bit, 0);
  endtask

  task automatic t_locked_ops;
    issue(2'd0, 20'h00100, 1'b0);
    chk("R4 boot program refused", a_permit, 0);
    issue(2'd0, 20'h04000, 1'b0);
    chk("R4 param program allowed", a_permit, 1);
    issue(2'd1, 20'h03FFF, 1'b0);
    chk("R4 boot erase refused", a_permit, 0);
    issue(2'd0, 20'h7F000, 1'b0);
    chk("R4 top boot program refused", b_permit, 0);
    issue(2'd2, 20'h00000, 1'b0);
    chk("R5 locked chip permit", a_permit, 1);
    chk("R5 locked chip lo", a_lo, 20'h04000);
    chk("R5 locked chip hi", a_hi, 20'hFFFFF);
    chk("R5 locked top lo", b_lo, 0);
    chk("R5 locked top hi", b_hi, 19'h7DFFF);
  endtask

  task automatic t_override;
    issue(2'd0, 20'h00100, 1'b1);
    chk("R6 override program", a_permit, 1);
    issue(2'd1, 20'h00000, 1'b1);
    chk("R6 override erase", a_permit, 1);
    issue(2'd2, 20'h00000, 1'b1);
    chk("R6 override chip lo", a_lo, 0);
    chk("R6 override chip top hi", b_hi, 19'h7FFFF);
    issue(2'd0, 20'h00100, 1'b0);
    chk("R6 override dropped", a_permit, 0);
  endtask

  task automatic t_lock_survives;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    issue(2'd3, 20'h00002, 1'b0);
    chk("R8 lock after reset", a_lock_bit, 1);
    issue(2'd2, 20'h00000, 1'b1);
    issue(2'd3, 20'h00002, 1'b0);
    chk("R8 lock after chip erase", a_lock_bit, 1);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0; req_valid = 1'b1; req_kind = 2'd0; a_addr = 20'h04000;
    @(negedge clk);
    chk("R9 valid", a_rsp_valid, 1);
    chk("R9 ready low while stalled", a_req_ready, 0);
    chk("R9 first sector", a_sector, 1);
    a_addr = 20'h08000;
    @(negedge clk);
    chk("R9 held sector", a_sector, 1);
    chk("R9 held lo", a_lo, 20'h04000);
    rsp_ready = 1'b1;
    #1 chk("R9 ready follows rsp_ready", a_req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second sector", a_sector, 3);
    chk("R9 second lo", a_lo, 20'h08000);
    @(negedge clk);
    chk("R9 drained", a_rsp_valid, 0);
  endtask

  initial begin
    t_reset();
    t_map_bottom();
    t_map_top();
    t_sector_erase();
    t_chip_unlocked();
    t_lock();
    t_locked_ops();
    t_override();
    t_lock_survives();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule